// File: doc/BRIEF.md
# Strobed Serial Configuration Register Port

This block is a three-wire serial slave that lets a host configure a dual-bridge current-regulating driver. The host holds the strobe input low and clocks bits in on the serial clock. It then raises the strobe. On that rising edge the most recent 19-bit frame is committed to one of two 18-bit registers. One register is the data word, which holds the per-bridge current codes, directions, decay modes and gain range. The other is the control word, which holds the timing codes, clock source, rectification mode and run bit. The oldest bit in the shift register is driven onto a serial output. Devices can therefore be chained and loaded with one shared strobe.

All serial inputs pass through two-flop synchronizers and are edge-detected in the system clock domain, so every register update is synchronous to `clk`. A write-lock input blocks updates to the control word only. A supply-good input holds both registers and the shift register at zero while it is low. Both registers are decoded into named fields for the downstream regulation logic. Each register gives a one-cycle pulse whenever it takes a new value.

Top module: `strobe_cfg_port`

## Requirements
- R1: A bit of `ser_din` enters the shift register on each rising edge of `ser_clk` seen while `ser_strobe` is low. Clock edges seen while `ser_strobe` is high change neither the shift register nor `ser_dout`.
- R2: A frame is 18 payload bits, most significant first, followed by a select bit. Select 0 writes the data word and select 1 writes the control word. Payload bit n (n = 1..18) lands in bit n-1 of `data_word` or `ctrl_word`.
- R3: On a rising edge of `ser_strobe`, the last 19 bits shifted in are committed, however many clocks came before them.
- R4: While `wr_lock` is high, a frame with select 1 leaves `ctrl_word` unchanged. Frames with select 0 are written regardless of `wr_lock`.
- R5: `ser_dout` carries the bit that was shifted in 19 shifts earlier, which is zero after a clear.
- R6: While `supply_ok` is low, `data_word`, `ctrl_word` and the shift register are held at zero and no write takes place. They stay zero after `supply_ok` returns high, until the next frame. After reset all outputs are zero.
- R7: Data fields: `b1_level` = payload bits 1..6 (LSB at bit 1), `b1_dir` = bit 7, `b1_slow` = bit 8 (1 forces slow decay, 0 allows mixed), `b2_level` = bits 9..14, `b2_dir` = bit 15, `b2_slow` = bit 16, `gain_sel` = bits 17..18.
- R8: Control fields: `blank_sel` = payload bits 1..2, `toff_code` = bits 3..7, `tfd_code` = bits 8..11, `mclk_sel` = bits 12..13, `rect_mode` = bits 14..15, `test_bits` = bits 16..17, `run_en` = bit 18 (0 means low-power idle).
- R9: `data_upd` or `ctrl_upd` is high for exactly one cycle in the cycle the matching register takes new data. The two pulses are never high together, and a blocked write produces no pulse.
- R10: With the inputs stable before a `clk` edge, an input change is acted on at the third rising `clk` edge after it. For example, a strobe rise shows on `data_upd` after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in |
| ser_strobe | input | 1 | Strobe: low to shift, rising edge commits |
| ser_dout | output | 1 | Oldest shift-register bit, for chaining or readback |
| wr_lock | input | 1 | High blocks control-word writes |
| supply_ok | input | 1 | Low clears and holds both registers |
| data_word | output | 18 | Data register, payload bits 1..18 |
| ctrl_word | output | 18 | Control register, payload bits 1..18 |
| data_upd | output | 1 | One-cycle pulse on data-word write |
| ctrl_upd | output | 1 | One-cycle pulse on control-word write |
| b1_level | output | 6 | Bridge 1 current code |
| b1_dir | output | 1 | Bridge 1 direction |
| b1_slow | output | 1 | Bridge 1 forced slow decay |
| b2_level | output | 6 | Bridge 2 current code |
| b2_dir | output | 1 | Bridge 2 direction |
| b2_slow | output | 1 | Bridge 2 forced slow decay |
| gain_sel | output | 2 | Current range select |
| blank_sel | output | 2 | Blanking time code |
| toff_code | output | 5 | Fixed off-time code |
| tfd_code | output | 4 | Fast-decay portion code |
| mclk_sel | output | 2 | Master clock source select |
| rect_mode | output | 2 | Synchronous rectification mode |
| test_bits | output | 2 | Reserved field |
| run_en | output | 1 | 1 = active, 0 = idle |

## Verification
The port is driven with plain data and control frames using distinct field patterns, so that a swapped or shifted field position shows up in the decoded outputs. A frame preceded by surplus clocks separates "keep the last 19 bits" from "keep the first 19". Clocking with the strobe high, then re-strobing with no clocks, shows whether stray edges leaked into the shift register. Writes to the control word with the lock high and to the data word with the lock high separate the two guard paths. A supply drop in the middle of traffic checks that both registers clear. A strobe timed cycle by cycle pins the three-edge latency.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int PAY_W   = 18;
  localparam int FRAME_W = PAY_W + 1;
  localparam int NSLOT   = 2;

  // synchronized input bundle positions
  localparam int IX_SCLK = 4;
  localparam int IX_STRB = 3;
  localparam int IX_DIN  = 2;
  localparam int IX_LOCK = 1;
  localparam int IX_SUP  = 0;
  localparam int IN_W    = 5;
  // idle values: clock low, strobe high, locked, supply not yet good
  localparam logic [IN_W-1:0] IN_RST = 5'b01010;

  // data word, payload bit 18 down to bit 1
  typedef struct packed {
    logic [1:0] gain;
    logic       b2_slow;
    logic       b2_dir;
    logic [5:0] b2_lvl;
    logic       b1_slow;
    logic       b1_dir;
    logic [5:0] b1_lvl;
  } data_fields_t;

  // control word, payload bit 18 down to bit 1
  typedef struct packed {
    logic       run;
    logic [1:0] test;
    logic [1:0] rect;
    logic [1:0] mclk;
    logic [3:0] tfd;
    logic [4:0] toff;
    logic [1:0] blank;
  } ctrl_fields_t;

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cfgp_front.sv
module cfgp_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic strb_s,
  output logic shift_en,
  output logic latch_en
);

  logic sclk_q, strb_q;
  logic sclk_d, strb_d;

  always_comb begin
    sclk_d = sclk_s;
    strb_d = strb_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      strb_q <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
      strb_q <= strb_d;
    end
  end

  // shifting only while strobe low; commit on strobe rise
  assign shift_en = sclk_s & ~sclk_q & ~strb_s;
  assign latch_en = strb_s & ~strb_q;

endmodule

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clr)           sr_d = '0;
    else if (shift_en) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q;

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank #(
  parameter int               PW    = 18,
  parameter int               NS    = 2,
  parameter logic [NS-1:0]    GUARD = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             latch_en,
  input  logic             lock,
  input  logic [PW:0]      frame,
  output logic [NS*PW-1:0] bank_q,
  output logic [NS-1:0]    upd
);

  localparam int SELW = (NS > 1) ? $clog2(NS) : 1;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic [PW-1:0] word_q, word_d;
    logic          upd_q, upd_d;
    logic          hit, blocked, wen;

    always_comb begin
      hit     = latch_en & (frame[SELW-1:0] == SELW'(g));
      blocked = GUARD[g] & lock;
      wen     = hit & ~blocked;
      word_d  = word_q;
      upd_d   = 1'b0;
      if (clr) begin
        word_d = '0;
      end else if (wen) begin
        word_d = frame[PW:1];
        upd_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        upd_q  <= 1'b0;
      end else begin
        word_q <= word_d;
        upd_q  <= upd_d;
      end
    end

    assign bank_q[g*PW +: PW] = word_q;
    assign upd[g]             = upd_q;
  end

endmodule

// File: rtl/strobe_cfg_port.sv
module strobe_cfg_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       ser_strobe,
  output logic       ser_dout,
  input  logic       wr_lock,
  input  logic       supply_ok,
  output logic [17:0] data_word,
  output logic [17:0] ctrl_word,
  output logic       data_upd,
  output logic       ctrl_upd,
  output logic [5:0] b1_level,
  output logic       b1_dir,
  output logic       b1_slow,
  output logic [5:0] b2_level,
  output logic       b2_dir,
  output logic       b2_slow,
  output logic [1:0] gain_sel,
  output logic [1:0] blank_sel,
  output logic [4:0] toff_code,
  output logic [3:0] tfd_code,
  output logic [1:0] mclk_sel,
  output logic [1:0] rect_mode,
  output logic [1:0] test_bits,
  output logic       run_en
);

  logic               rst_q_n;
  logic [IN_W-1:0]    in_raw, in_s;
  logic               sclk_s, strb_s, din_s, lock_s, sup_ok_s;
  logic               shift_en, latch_en;
  logic [FRAME_W-1:0] frame_q;
  logic [NSLOT*PAY_W-1:0] bank_q;
  logic [NSLOT-1:0]   upd;
  data_fields_t       dfld;
  ctrl_fields_t       cfld;

  // asynchronous assert, synchronous release
  cfgp_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_q_n)
  );

  always_comb begin
    in_raw          = '0;
    in_raw[IX_SCLK] = ser_clk;
    in_raw[IX_STRB] = ser_strobe;
    in_raw[IX_DIN]  = ser_din;
    in_raw[IX_LOCK] = wr_lock;
    in_raw[IX_SUP]  = supply_ok;
  end

  cfgp_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (in_raw),
    .q     (in_s)
  );

  assign sclk_s   = in_s[IX_SCLK];
  assign strb_s   = in_s[IX_STRB];
  assign din_s    = in_s[IX_DIN];
  assign lock_s   = in_s[IX_LOCK];
  assign sup_ok_s = in_s[IX_SUP];

  cfgp_front u_front (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sclk_s   (sclk_s),
    .strb_s   (strb_s),
    .shift_en (shift_en),
    .latch_en (latch_en)
  );

  cfgp_shreg #(.W(FRAME_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (~sup_ok_s),
    .shift_en (shift_en),
    .din      (din_s),
    .q        (frame_q)
  );

  cfgp_bank #(.PW(PAY_W), .NS(NSLOT), .GUARD(2'b10)) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (~sup_ok_s),
    .latch_en (latch_en),
    .lock     (lock_s),
    .frame    (frame_q),
    .bank_q   (bank_q),
    .upd      (upd)
  );

  assign ser_dout  = frame_q[FRAME_W-1];
  assign data_word = bank_q[0 +: PAY_W];
  assign ctrl_word = bank_q[PAY_W +: PAY_W];
  assign data_upd  = upd[0];
  assign ctrl_upd  = upd[1];

  assign dfld = data_fields_t'(data_word);
  assign cfld = ctrl_fields_t'(ctrl_word);

  assign b1_level  = dfld.b1_lvl;
  assign b1_dir    = dfld.b1_dir;
  assign b1_slow   = dfld.b1_slow;
  assign b2_level  = dfld.b2_lvl;
  assign b2_dir    = dfld.b2_dir;
  assign b2_slow   = dfld.b2_slow;
  assign gain_sel  = dfld.gain;
  assign blank_sel = cfld.blank;
  assign toff_code = cfld.toff;
  assign tfd_code  = cfld.tfd;
  assign mclk_sel  = cfld.mclk;
  assign rect_mode = cfld.rect;
  assign test_bits = cfld.test;
  assign run_en    = cfld.run;

endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        sup_ok_s,
  input logic        lock_s,
  input logic        shift_en,
  input logic        ser_dout,
  input logic        data_upd,
  input logic        ctrl_upd,
  input logic [17:0] data_word,
  input logic [17:0] ctrl_word
);

  assert_upd_excl_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({data_upd, ctrl_upd}));

  assert_upd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (data_upd || ctrl_upd) |=> !(data_upd || ctrl_upd));

  assert_supply_clear_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sup_ok_s |=> (data_word == '0 && ctrl_word == '0 && !data_upd && !ctrl_upd));

  assert_lock_guard_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl_upd |-> !$past(lock_s));

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctrl_word != $past(ctrl_word)) |-> (ctrl_upd || !$past(sup_ok_s)));

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (data_word != $past(data_word)) |-> (data_upd || !$past(sup_ok_s)));

  assert_dout_hold_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!$past(shift_en) && $past(sup_ok_s)) |-> $stable(ser_dout));

endmodule

bind strobe_cfg_port cfgp_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .sup_ok_s  (sup_ok_s),
  .lock_s    (lock_s),
  .shift_en  (shift_en),
  .ser_dout  (ser_dout),
  .data_upd  (data_upd),
  .ctrl_upd  (ctrl_upd),
  .data_word (data_word),
  .ctrl_word (ctrl_word)
);

// File: tb/strobe_cfg_port_tb.sv
`timescale 1ns/1ps
module strobe_cfg_port_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n, ser_clk, ser_din, ser_strobe, wr_lock, supply_ok;
  logic ser_dout, data_upd, ctrl_upd, b1_dir, b1_slow, b2_dir, b2_slow, run_en;
  logic [17:0] data_word, ctrl_word;
  logic [5:0] b1_level, b2_level;
  logic [1:0] gain_sel, blank_sel, mclk_sel, rect_mode, test_bits;
  logic [4:0] toff_code;
  logic [3:0] tfd_code;

  strobe_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_strobe(ser_strobe), .ser_dout(ser_dout), .wr_lock(wr_lock),
    .supply_ok(supply_ok), .data_word(data_word), .ctrl_word(ctrl_word),
    .data_upd(data_upd), .ctrl_upd(ctrl_upd), .b1_level(b1_level),
    .b1_dir(b1_dir), .b1_slow(b1_slow), .b2_level(b2_level), .b2_dir(b2_dir),
    .b2_slow(b2_slow), .gain_sel(gain_sel), .blank_sel(blank_sel),
    .toff_code(toff_code), .tfd_code(tfd_code), .mclk_sel(mclk_sel),
    .rect_mode(rect_mode), .test_bits(test_bits), .run_en(run_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // history of sampled inputs: {sclk, strobe, din, lock, supply}
  logic [4:0] hist [3];
  logic [17:0] m_data, m_ctrl;
  logic [18:0] m_sr;
  logic m_du, m_cu;
  int rel_cnt;
  bit model_on = 0;

  always @(posedge clk) begin
    logic [4:0] now_v, s2, pv;
    now_v = {ser_clk, ser_strobe, ser_din, wr_lock, supply_ok};
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0; else rel_cnt++;
      for (int i = 0; i < 3; i++) hist[i] = 5'b01010;
      m_data = '0; m_ctrl = '0; m_sr = '0; m_du = 0; m_cu = 0;
    end else begin
      s2 = hist[1]; pv = hist[2];
      m_du = 0; m_cu = 0;
      if (!s2[0]) begin
        m_data = '0; m_ctrl = '0; m_sr = '0;
      end else begin
        if (s2[4] && !pv[4] && !s2[3]) m_sr = {m_sr[17:0], s2[2]};
        if (s2[3] && !pv[3]) begin
          if (!m_sr[0]) begin m_data = m_sr[18:1]; m_du = 1; end
          else if (!s2[1]) begin m_ctrl = m_sr[18:1]; m_cu = 1; end
        end
      end
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = now_v;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R2 R3 data_word vs model", 32'(data_word), 32'(m_data));
      chk("R2 R4 ctrl_word vs model", 32'(ctrl_word), 32'(m_ctrl));
      chk("R9 update pulses vs model", {30'd0, ctrl_upd, data_upd}, {30'd0, m_cu, m_du});
      chk("R5 ser_dout vs model", 32'(ser_dout), 32'(m_sr[18]));
      chk("R7 data fields", {b1_level, b1_dir, b1_slow, b2_level, b2_dir, b2_slow, gain_sel},
          {m_data[5:0], m_data[6], m_data[7], m_data[13:8], m_data[14], m_data[15], m_data[17:16]});
      chk("R8 ctrl fields", {blank_sel, toff_code, tfd_code, mclk_sel, rect_mode, test_bits, run_en},
          {m_ctrl[1:0], m_ctrl[6:2], m_ctrl[10:7], m_ctrl[12:11], m_ctrl[14:13], m_ctrl[16:15], m_ctrl[17]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_clk = 1'b0; ser_din = b; tick(3);
    ser_clk = 1'b1; tick(3);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(logic [17:0] pay, logic sel, int pre);
    ser_strobe = 1'b0; tick(3);
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    for (int i = 17; i >= 0; i--) send_bit(pay[i]);
    send_bit(sel);
    tick(3);
    ser_strobe = 1'b1; tick(6);
  endtask

  logic [17:0] dat_a, dat_b, ctl_a, ctl_b;

  initial begin
    rst_n = 0; ser_clk = 0; ser_din = 0; ser_strobe = 1; wr_lock = 0; supply_ok = 0;
    rel_cnt = 0;
    tick(5);
    rst_n = 1;
    tick(1);
    model_on = 1;
    // R6: reset state
    chk("R6 reset data_word", 32'(data_word), 0);
    chk("R6 reset ctrl_word", 32'(ctrl_word), 0);
    chk("R6 reset dout/upd", {29'd0, ser_dout, data_upd, ctrl_upd}, 0);
    supply_ok = 1; tick(6);

    // R2 R7: data frame
    dat_a = {2'b10, 1'b1, 1'b0, 6'h15, 1'b0, 1'b1, 6'h2B};
    send_frame(dat_a, 1'b0, 0);
    chk("R2 data written", 32'(data_word), 32'(dat_a));
    chk("R7 b1 fields", {b1_level, b1_dir, b1_slow}, {6'h2B, 1'b1, 1'b0});
    chk("R7 b2/gain fields", {b2_level, b2_dir, b2_slow, gain_sel}, {6'h15, 1'b0, 1'b1, 2'b10});

    // R2 R8: control frame, unlocked
    ctl_a = {1'b1, 2'b00, 2'b11, 2'b01, 4'hA, 5'h13, 2'b10};
    send_frame(ctl_a, 1'b1, 0);
    chk("R2 ctrl written", 32'(ctrl_word), 32'(ctl_a));
    chk("R8 ctrl fields", {run_en, test_bits, rect_mode, mclk_sel, tfd_code, toff_code, blank_sel},
        {1'b1, 2'b00, 2'b11, 2'b01, 4'hA, 5'h13, 2'b10});

    // R4: locked control write ignored, data write still goes through
    wr_lock = 1;
    ctl_b = 18'h15A5A;
    send_frame(ctl_b, 1'b1, 0);
    chk("R4 locked ctrl unchanged", 32'(ctrl_word), 32'(ctl_a));
    dat_b = 18'h2C3F1;
    send_frame(dat_b, 1'b0, 0);
    chk("R4 data written under lock", 32'(data_word), 32'(dat_b));
    wr_lock = 0;

    // R3: surplus leading clocks, last 19 kept
    send_frame(18'h00F0F, 1'b0, 7);
    chk("R3 last 19 bits kept", 32'(data_word), 32'h00F0F);

    // R1: clocks with strobe high do not shift; re-strobe re-commits same frame
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R1 dout unchanged by high-strobe clocks", 32'(ser_dout), 0);
    ser_strobe = 0; tick(4); ser_strobe = 1; tick(6);
    chk("R1 re-strobe gives same data", 32'(data_word), 32'h00F0F);

    // R5: chain output delays by 19 shifts
    ser_strobe = 0; tick(3);
    for (int i = 17; i >= 0; i--) send_bit(dat_a[i]);
    send_bit(1'b0);
    tick(4);
    chk("R5 dout = first bit of frame", 32'(ser_dout), 32'(dat_a[17]));
    send_bit(1'b0); tick(4);
    chk("R5 dout = second bit of frame", 32'(ser_dout), 32'(dat_a[16]));
    send_bit(1'b1);
    // frame now ends with select 1: dat_a[15:0],0,0,1 -> control
    tick(3);

    // R10: latency of strobe rise to pulse
    ser_strobe = 1;
    tick(1); chk("R10 no pulse after edge 1", 32'(ctrl_upd), 0);
    tick(1); chk("R10 no pulse after edge 2", 32'(ctrl_upd), 0);
    tick(1); chk("R10 pulse after edge 3", 32'(ctrl_upd), 1);
    tick(1); chk("R9 pulse lasts one cycle", 32'(ctrl_upd), 0);
    chk("R2 chained ctrl value", 32'(ctrl_word), 32'({dat_a[15:0], 2'b00}));
    tick(4);

    // R6: supply drop clears and blocks writes
    supply_ok = 0; tick(5);
    chk("R6 data cleared", 32'(data_word), 0);
    chk("R6 ctrl cleared", 32'(ctrl_word), 0);
    send_frame(dat_a, 1'b0, 0);
    chk("R6 write blocked while supply low", 32'(data_word), 0);
    supply_ok = 1; tick(5);
    chk("R6 zero after supply return", {ctrl_word, data_word}, 0);
    chk("R6 shift register cleared", 32'(ser_dout), 0);
    send_frame(18'h3FFFF, 1'b0, 0);
    chk("R7 all-ones data", {b1_level, b2_level, gain_sel}, {6'h3F, 6'h3F, 2'b11});

    tick(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule